// File: doc/BRIEF.md
# CPU Power-Domain Controller with Interrupt Wakeup

This block sequences the power of one CPU domain that holds a core, its timer and its interrupt controller. Software arms the controller through a small 32-bit register port. The next time the core signals wait-for-interrupt with no interrupt line active, the controller runs a fixed sequence. It raises isolation, removes power and holds the core in reset. It then waits until an enabled, unmasked interrupt source becomes active. When that happens it restores power, drops isolation and finally releases the core reset. The core then fetches from a 64-bit restart address that software programmed into the block.

All state inside the domain is lost in the off period, so the controller itself sits outside the domain. The controller keeps the arm bit, the wakeup configuration and the restart address. Interrupt lines below a configurable base number cannot wake the domain. Line n at or above the base maps to wakeup mask bit n minus the base. Each step of the sequence waits a parameterized number of cycles. A status register shows the sequencer state and whether the most recent wait-for-interrupt actually removed power.

Top module: `pwrdom_ctrl`

## Requirements
- R1: After reset the domain is powered (`dom_pwr_on`=1), `dom_iso`=0, `core_rst_n`=1, `core_reset_vec` is zero and every register reads zero.
- R2: Bit 0 of the control word at offset 0x00 arms the controller when written 1 and disarms it when written 0. It reads back in bit 0. While the controller is disarmed, a wait-for-interrupt has no effect on the outputs.
- R3: When the controller is armed and `core_wfi` is seen with no `irq` line high, `dom_iso` rises while power stays on. Power is removed exactly T_ISO cycles later.
- R4: When the controller is armed and `core_wfi` is seen while any `irq` line is high, there is no power-down. The status state stays at ARMED (code 1) and the power-down flag is cleared.
- R5: While power is removed, `core_rst_n` is low and `dom_iso` is high.
- R6: Wakeup requires bit 0 of the enable word at offset 0x10, together with a high `irq` line n >= 16 whose mask bit n-16 is set. Mask word i sits at offset 0x20+4*i, and its bit j belongs to line 16+32*i+j. Lines 0 to 15 never wake the domain.
- R7: The wakeup condition is sampled only while power is off. A qualifying interrupt that comes and goes during isolation does not stop the power-down. With wakeup disabled, the domain stays off.
- R8: On wakeup, power returns first. `dom_iso` falls T_PWR cycles later and `core_rst_n` rises T_RST cycles after that, at which point all three outputs are back at the values they hold before a power-down.
- R9: The arm bit stays set through a power cycle. The controller returns to ARMED, and the next qualifying wait-for-interrupt powers the domain down again.
- R10: The status word at offset 0x0C gives the state in bits [2:0]: IDLE 0, ARMED 1, ISOLATE 2, OFF 3, POWER_ON 4, RELEASE 5. Bit 8 is 1 when the last wait-for-interrupt seen while armed removed power.
- R11: The restart address low word sits at offset 0x04 and the high word at 0x08. Both read back, and `core_reset_vec` equals {high, low}.
- R12: Reads of unmapped or misaligned offsets return zero. Writes to them, and writes to the status word, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| core_wfi | input | 1 | Core is in wait-for-interrupt |
| irq | input | NUM_IRQ | Level interrupt lines |
| dom_pwr_on | output | 1 | Power switch enable for the domain |
| dom_iso | output | 1 | Isolation clamp enable for the domain outputs |
| core_rst_n | output | 1 | Active-low reset to the core |
| core_reset_vec | output | 64 | Address the core fetches from after reset |

## Verification
The embedded properties watch ordering on every cycle. Isolation must lead any loss of power, the core reset must be held while power is off, and power may return only on the wakeup term. A pending line must block a power-down, the off state must persist without a wake, isolation may drop only with power on and reset held, and a control write must take effect in the next cycle. Only the bench scenarios can show the exact step lengths and the mask-bit-to-line mapping across words. The same applies to lines below the base being ignored, a wake pulse during isolation being disregarded, the arm bit surviving a power cycle, and the register map with its unmapped offsets.

// File: rtl/pwrdom_pkg.sv
package pwrdom_pkg;

   typedef enum logic [2:0] {
      PD_IDLE    = 3'd0,
      PD_ARMED   = 3'd1,
      PD_ISOLATE = 3'd2,
      PD_OFF     = 3'd3,
      PD_ON      = 3'd4,
      PD_RELEASE = 3'd5
   } pd_state_e;

   localparam int OFS_ARM      = 'h00;
   localparam int OFS_ENTRY_LO = 'h04;
   localparam int OFS_ENTRY_HI = 'h08;
   localparam int OFS_STATUS   = 'h0C;
   localparam int OFS_WAKE_EN  = 'h10;
   localparam int OFS_MASK0    = 'h20;

   localparam int STATUS_PD_BIT = 8;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pwrdom_regs.sv
module pwrdom_regs
   import pwrdom_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int NUM_WAKE = 160
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   input  pd_state_e           st_i,
   input  logic                last_pd_i,
   output logic                arm_o,
   output logic                wake_en_o,
   output logic [NUM_WAKE-1:0] mask_o,
   output logic [63:0]         entry_o
);

   localparam int MASK_WORDS = (NUM_WAKE + 31) / 32;
   localparam int WA_W       = ADDR_W - 2;

   logic [WA_W-1:0] wi;
   logic            aligned;
   logic            wr, rd;
   logic            hit_arm, hit_lo, hit_hi, hit_st, hit_wen;
   logic [MASK_WORDS-1:0] hit_mask;
   logic            any_hit;

   logic        arm_q, wen_q;
   logic [31:0] lo_q, hi_q;
   logic [31:0] mask_q [MASK_WORDS];
   logic [31:0] rd_mux;

   assign wi      = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign wr      = req && we;
   assign rd      = req && !we;

   assign hit_arm = aligned && (wi == WA_W'(OFS_ARM >> 2));
   assign hit_lo  = aligned && (wi == WA_W'(OFS_ENTRY_LO >> 2));
   assign hit_hi  = aligned && (wi == WA_W'(OFS_ENTRY_HI >> 2));
   assign hit_st  = aligned && (wi == WA_W'(OFS_STATUS >> 2));
   assign hit_wen = aligned && (wi == WA_W'(OFS_WAKE_EN >> 2));
   assign any_hit = hit_arm | hit_lo | hit_hi | hit_st | hit_wen | (|hit_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         wen_q <= 1'b0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else if (wr) begin
         if (hit_arm) arm_q <= wdata[0];
         if (hit_wen) wen_q <= wdata[0];
         if (hit_lo)  lo_q  <= wdata;
         if (hit_hi)  hi_q  <= wdata;
      end
   end

   for (genvar i = 0; i < MASK_WORDS; i++) begin : g_mask
      localparam int LO = 32 * i;
      localparam int W  = ((NUM_WAKE - LO) >= 32) ? 32 : (NUM_WAKE - LO);
      localparam logic [31:0] VMASK = (W == 32) ? 32'hFFFF_FFFF : ((32'h1 << W) - 32'h1);

      assign hit_mask[i] = aligned && (wi == WA_W'((OFS_MASK0 >> 2) + i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                mask_q[i] <= '0;
         else if (wr && hit_mask[i]) mask_q[i] <= wdata & VMASK;
      end

      assign mask_o[LO +: W] = mask_q[i][W-1:0];
   end

   always_comb begin
      rd_mux = '0;
      if (hit_arm) rd_mux[0] = arm_q;
      if (hit_wen) rd_mux[0] = wen_q;
      if (hit_lo)  rd_mux    = lo_q;
      if (hit_hi)  rd_mux    = hi_q;
      if (hit_st) begin
         rd_mux[2:0]           = st_i;
         rd_mux[STATUS_PD_BIT] = last_pd_i;
      end
      for (int i = 0; i < MASK_WORDS; i++) begin
         if (hit_mask[i]) rd_mux = mask_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_mux;
   end

   assign arm_o     = arm_q;
   assign wake_en_o = wen_q;
   assign entry_o   = {hi_q, lo_q};

   assert_arm_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_arm) |=> (arm_o == $past(wdata[0])));

   assert_unmapped_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !any_hit) |=> (rdata == 32'h0));

endmodule

// File: rtl/pwrdom_wake.sv
module pwrdom_wake #(
   parameter int NUM_IRQ   = 176,
   parameter int WAKE_BASE = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_IRQ-1:0]            irq,
   input  logic [NUM_IRQ-WAKE_BASE-1:0]  mask,
   input  logic                          wake_en,
   output logic                          wake,
   output logic                          any_pending
);

   localparam int NUM_WAKE = NUM_IRQ - WAKE_BASE;

   logic [NUM_WAKE-1:0] wake_src;

   if (WAKE_BASE > 0) begin : g_offset
      assign wake_src = irq[NUM_IRQ-1:WAKE_BASE];
   end else begin : g_direct
      assign wake_src = irq;
   end

   assign wake        = wake_en && (|(wake_src & mask));
   assign any_pending = |irq;

   assert_wake_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> (wake_en && (|wake_src)));

endmodule

// File: rtl/pwrdom_seq.sv
module pwrdom_seq
   import pwrdom_pkg::*;
#(
   parameter int T_ISO = 4,
   parameter int T_PWR = 6,
   parameter int T_RST = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arm,
   input  logic      wfi,
   input  logic      pending,
   input  logic      wake,
   output pd_state_e st_o,
   output logic      last_pd_o,
   output logic      pwr_on,
   output logic      iso_en,
   output logic      core_rst_n
);

   localparam int MAXT  = max3(T_ISO, T_PWR, T_RST);
   localparam int CNT_W = (MAXT < 2) ? 1 : $clog2(MAXT);
   localparam logic [CNT_W-1:0] LD_ISO = CNT_W'(T_ISO - 1);
   localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(T_PWR - 1);
   localparam logic [CNT_W-1:0] LD_RST = CNT_W'(T_RST - 1);

   pd_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic             last_pd;
   logic             done;

   assign done = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= PD_IDLE;
         cnt     <= '0;
         last_pd <= 1'b0;
      end else begin
         unique case (st)
            PD_IDLE: if (arm) st <= PD_ARMED;
            PD_ARMED: begin
               if (!arm) st <= PD_IDLE;
               else if (wfi) begin
                  if (pending) last_pd <= 1'b0;
                  else begin
                     st      <= PD_ISOLATE;
                     cnt     <= LD_ISO;
                     last_pd <= 1'b1;
                  end
               end
            end
            PD_ISOLATE: begin
               if (done) st <= PD_OFF;
               else      cnt <= cnt - 1'b1;
            end
            PD_OFF: begin
               if (wake) begin
                  st  <= PD_ON;
                  cnt <= LD_PWR;
               end
            end
            PD_ON: begin
               if (done) begin
                  st  <= PD_RELEASE;
                  cnt <= LD_RST;
               end else cnt <= cnt - 1'b1;
            end
            PD_RELEASE: begin
               if (done) st <= PD_IDLE;
               else      cnt <= cnt - 1'b1;
            end
            default: st <= PD_IDLE;
         endcase
      end
   end

   assign st_o       = st;
   assign last_pd_o  = last_pd;
   assign pwr_on     = (st != PD_OFF);
   assign iso_en     = (st == PD_ISOLATE) || (st == PD_OFF) || (st == PD_ON);
   assign core_rst_n = !((st == PD_OFF) || (st == PD_ON) || (st == PD_RELEASE));

   assert_iso_before_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on) |-> $past(iso_en));

   assert_pending_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PD_ARMED && arm && wfi && pending) |=> (pwr_on && !iso_en));

   assert_reset_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on) |-> (!core_rst_n && iso_en));

   assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PD_OFF && !wake) |=> !pwr_on);

   assert_power_up_on_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on) |-> $past(wake));

   assert_iso_drop_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en) |-> (pwr_on && (!core_rst_n || $past(st) == PD_ISOLATE)));

endmodule

// File: rtl/pwrdom_ctrl.sv
module pwrdom_ctrl
   import pwrdom_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_IRQ   = 176,
   parameter int WAKE_BASE = 16,
   parameter int T_ISO     = 4,
   parameter int T_PWR     = 6,
   parameter int T_RST     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic               core_wfi,
   input  logic [NUM_IRQ-1:0] irq,
   output logic               dom_pwr_on,
   output logic               dom_iso,
   output logic               core_rst_n,
   output logic [63:0]        core_reset_vec
);

   localparam int NUM_WAKE   = NUM_IRQ - WAKE_BASE;
   localparam int MASK_WORDS = (NUM_WAKE + 31) / 32;
   localparam int MAP_END    = OFS_MASK0 + 4 * MASK_WORDS;

   if (NUM_WAKE < 1) begin : g_chk_wake
      $error("pwrdom_ctrl: WAKE_BASE must be below NUM_IRQ");
   end
   if (T_ISO < 1 || T_PWR < 1 || T_RST < 1) begin : g_chk_delay
      $error("pwrdom_ctrl: step delays must be at least one cycle");
   end
   if (ADDR_W < 3 || MAP_END > (1 << ADDR_W)) begin : g_chk_addr
      $error("pwrdom_ctrl: ADDR_W too narrow for the register map");
   end

   pd_state_e           st;
   logic                last_pd;
   logic                arm, wake_en, wake, pending;
   logic [NUM_WAKE-1:0] mask;

   pwrdom_regs #(
      .ADDR_W   (ADDR_W),
      .NUM_WAKE (NUM_WAKE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (bus_req),
      .we        (bus_we),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .rdata     (bus_rdata),
      .st_i      (st),
      .last_pd_i (last_pd),
      .arm_o     (arm),
      .wake_en_o (wake_en),
      .mask_o    (mask),
      .entry_o   (core_reset_vec)
   );

   pwrdom_wake #(
      .NUM_IRQ   (NUM_IRQ),
      .WAKE_BASE (WAKE_BASE)
   ) u_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq         (irq),
      .mask        (mask),
      .wake_en     (wake_en),
      .wake        (wake),
      .any_pending (pending)
   );

   pwrdom_seq #(
      .T_ISO (T_ISO),
      .T_PWR (T_PWR),
      .T_RST (T_RST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .wfi        (core_wfi),
      .pending    (pending),
      .wake       (wake),
      .st_o       (st),
      .last_pd_o  (last_pd),
      .pwr_on     (dom_pwr_on),
      .iso_en     (dom_iso),
      .core_rst_n (core_rst_n)
   );

endmodule

// File: tb/pwrdom_ctrl_tb.sv
module pwrdom_ctrl_tb;

   localparam int ADDR_W  = 8;
   localparam int NUM_IRQ = 176;
   localparam int T_ISO   = 4;
   localparam int T_PWR   = 6;
   localparam int T_RST   = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_req = 1'b0, bus_we = 1'b0;
   logic [ADDR_W-1:0]  bus_addr = '0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic               core_wfi = 1'b0;
   logic [NUM_IRQ-1:0] irq = '0;
   logic               dom_pwr_on, dom_iso, core_rst_n;
   logic [63:0]        core_reset_vec;

   always #2.5 clk = ~clk;

   pwrdom_ctrl #(
      .ADDR_W (ADDR_W), .NUM_IRQ (NUM_IRQ), .WAKE_BASE (16),
      .T_ISO (T_ISO), .T_PWR (T_PWR), .T_RST (T_RST)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .core_wfi (core_wfi), .irq (irq),
      .dom_pwr_on (dom_pwr_on), .dom_iso (dom_iso), .core_rst_n (core_rst_n),
      .core_reset_vec (core_reset_vec)
   );

   typedef struct {
      logic [2:0] tup;
      int         dur;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   mon_en = 1'b0;
   bit   done_flag = 1'b0;

   // output tuple {dom_pwr_on, dom_iso, core_rst_n}
   localparam logic [2:0] TP_RUN = 3'b101;
   localparam logic [2:0] TP_ISO = 3'b111;
   localparam logic [2:0] TP_OFF = 3'b010;
   localparam logic [2:0] TP_ON  = 3'b110;
   localparam logic [2:0] TP_REL = 3'b100;

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] tup, input int dur, input string tag);
      exp_t e;
      e.tup = tup; e.dur = dur; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, {32'h0, d}, {32'h0, exp});
   endtask

   task automatic wfi_pulse();
      @(negedge clk); core_wfi = 1'b1;
      @(negedge clk); core_wfi = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input string tag);
      int k;
      k = 0;
      while (q.size() != 0 && k < 300) begin
         @(negedge clk);
         k++;
      end
      chk({tag, " sequence completed"}, 64'(q.size()), 64'd0);
      q.delete();
   endtask

   // scoreboard monitor: every change of the output tuple must match the
   // next expected item, including how long the previous tuple was held
   logic [2:0] prev_tup = TP_RUN;
   int         held = 0;
   always @(negedge clk) begin
      logic [2:0] cur;
      exp_t       e;
      if (mon_en) begin
         cur = {dom_pwr_on, dom_iso, core_rst_n};
         held++;
         if (cur !== prev_tup) begin
            n_chk++;
            if (q.size() == 0) begin
               n_bad++;
               $display("FAIL R2 unexpected output change: actual %b expected %b", cur, prev_tup);
            end else begin
               e = q.pop_front();
               if (cur !== e.tup || (e.dur >= 0 && held != e.dur)) begin
                  n_bad++;
                  $display("FAIL %s: actual %b after %0d cycles expected %b after %0d cycles",
                           e.tag, cur, held, e.tup, e.dur);
               end
            end
            prev_tup = cur;
            held = 0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_up();
      end
   end

   initial begin
      logic [31:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 outputs", {61'h0, dom_pwr_on, dom_iso, core_rst_n}, {61'h0, TP_RUN});
      chk("R1 reset vector", core_reset_vec, 64'h0);
      rd_chk("R1 arm", 'h00, 32'h0);
      rd_chk("R1 status", 'h0C, 32'h0);
      rd_chk("R1 wake enable", 'h10, 32'h0);
      rd_chk("R1 mask word 0", 'h20, 32'h0);
      mon_en = 1'b1;

      // R2 disarmed WFI has no effect; arm/disarm and read back
      wfi_pulse();
      idle(10);
      rd_chk("R2 disarmed wfi stays idle", 'h0C, 32'h0);
      wr('h00, 32'hFFFF_FFFF);
      rd_chk("R2 arm reads back", 'h00, 32'h1);
      idle(2);
      rd_chk("R10 armed status", 'h0C, 32'h1);
      wr('h00, 32'h0);
      rd_chk("R2 disarm reads back", 'h00, 32'h0);
      rd_chk("R2 disarmed status", 'h0C, 32'h0);

      // R11 restart address
      wr('h04, 32'h8000_1234);
      wr('h08, 32'h0000_0004);
      chk("R11 reset vector", core_reset_vec, 64'h0000_0004_8000_1234);
      rd_chk("R11 low word", 'h04, 32'h8000_1234);
      rd_chk("R11 high word", 'h08, 32'h0000_0004);

      // R12 unmapped, misaligned and status writes ignored
      wr('h14, 32'hFFFF_FFFF);
      wr('h40, 32'hFFFF_FFFF);
      wr('h05, 32'hFFFF_FFFF);
      wr('h01, 32'hFFFF_FFFF);
      wr('h0C, 32'hFFFF_FFFF);
      rd_chk("R12 unmapped read 0x14", 'h14, 32'h0);
      rd_chk("R12 unmapped read 0x40", 'h40, 32'h0);
      rd_chk("R12 misaligned read", 'h05, 32'h0);
      rd_chk("R12 arm untouched", 'h00, 32'h0);
      rd_chk("R12 wake enable untouched", 'h10, 32'h0);
      rd_chk("R12 mask untouched", 'h20, 32'h0);
      rd_chk("R12 low word untouched", 'h04, 32'h8000_1234);
      rd_chk("R12 status untouched", 'h0C, 32'h0);

      // R6 wakeup configuration
      wr('h10, 32'h1);
      wr('h20, 32'h0000_0001);   // line 16
      wr('h2C, 32'h0000_0080);   // line 16+96+7 = 119
      wr('h30, 32'hFFFF_FFFF);   // lines 144..175
      rd_chk("R6 wake enable", 'h10, 32'h1);
      rd_chk("R6 mask word 3", 'h2C, 32'h0000_0080);
      rd_chk("R6 mask word 4", 'h30, 32'hFFFF_FFFF);

      // R4 pending line blocks power-down
      wr('h00, 32'h1);
      idle(2);
      irq[3] = 1'b1;
      wfi_pulse();
      idle(10);
      rd_chk("R4 stays armed, flag clear", 'h0C, 32'h1);
      irq[3] = 1'b0;

      // R3 power-down, R5 held off, R6 ignored lines, R8 power-up order
      push(TP_ISO, -1, "R3 isolation first");
      push(TP_OFF, T_ISO, "R3 power off after isolation delay");
      wfi_pulse();
      idle(T_ISO + 4);
      rd_chk("R10 off status with flag", 'h0C, 32'h0000_0103);
      chk("R5 reset and isolation while off", {61'h0, dom_pwr_on, dom_iso, core_rst_n}, {61'h0, TP_OFF});
      irq[5] = 1'b1;
      idle(10);
      rd_chk("R6 line below base does not wake", 'h0C, 32'h0000_0103);
      irq[5] = 1'b0;
      irq[17] = 1'b1;
      idle(10);
      rd_chk("R6 unmasked line does not wake", 'h0C, 32'h0000_0103);
      irq[17] = 1'b0;
      push(TP_ON, -1, "R8 power returns first");
      push(TP_REL, T_PWR, "R8 isolation drops after power delay");
      push(TP_RUN, T_RST, "R8 reset released after reset delay");
      irq[119] = 1'b1;
      drain("R8");
      irq[119] = 1'b0;

      // R9 arm survives and the controller is armed again
      rd_chk("R9 arm still set", 'h00, 32'h1);
      rd_chk("R9 back to armed", 'h0C, 32'h0000_0101);

      // R7 wake pulse during isolation is ignored
      push(TP_ISO, -1, "R9 second power-down isolation");
      push(TP_OFF, T_ISO, "R9 second power-down off");
      @(negedge clk); core_wfi = 1'b1;
      @(negedge clk); core_wfi = 1'b0; irq[16] = 1'b1;
      @(negedge clk); irq[16] = 1'b0;
      idle(T_ISO + 6);
      rd_chk("R7 pulse during isolation ignored", 'h0C, 32'h0000_0103);

      // R7 wakeup disabled keeps the domain off
      wr('h10, 32'h0);
      irq[16] = 1'b1;
      idle(12);
      rd_chk("R7 wake disabled stays off", 'h0C, 32'h0000_0103);
      push(TP_ON, -1, "R7 wake after enable");
      push(TP_REL, T_PWR, "R8 second isolation drop");
      push(TP_RUN, T_RST, "R8 second reset release");
      wr('h10, 32'h1);
      drain("R7");
      irq[16] = 1'b0;

      wr('h00, 32'h0);
      idle(2);
      rd_chk("R2 disarm after cycle", 'h0C, 32'h0000_0100);

      done_flag = 1'b1;
      finish_up();
   end

endmodule